// File: doc/BRIEF.md
# LCD Sync and Data-Window Timing Generator

This block produces the raster timing for a 320x240 TFT panel that is fed over a parallel pixel bus. A two-bit pixel mode says how many bus clocks carry one pixel: one, two or three. Every horizontal figure (line length, sync width, position of the first pixel) is scaled by that factor. The first-pixel position also carries a small per-mode correction. This correction absorbs the latency of an external packing stage. The block drives active-low horizontal and vertical syncs and a data-valid strobe over the active pixel clocks. It also exposes its column and line counters, so that a fetch engine can follow the raster.

A start pulse launches the raster. The mode is captured at that moment and holds until a stop pulse returns the block to idle. Pixel data, fetching and byte packing are handled elsewhere. This block only produces timing and enables. All outputs are registered.

Top module: `lcd_timing_gen`

## Requirements
- R1: After a synchronous reset, hsync_n and vsync_n are 1, data_valid is 0, and col_o and line_o are 0.
- R2: The pix_mode encoding is 2'b00 for one clock per pixel (correction 0), 2'b01 for two (correction DLY_M1 = 3), and 2'b10 for three (correction DLY_M2 = 5). A start with pix_mode 2'b11 is ignored and all outputs stay idle.
- R3: On the first clock after an accepted start, col_o and line_o are 0 and both syncs are low.
- R4: While running, col_o counts 0 to H_TOTAL x cpp - 1 and then wraps to 0. Each wrap advances line_o, which wraps after V_ACTIVE + V_BLANK lines.
- R5: hsync_n is low exactly on columns 0 to H_SYNC x cpp - 1 of every line.
- R6: vsync_n is low only on line 0, columns 0 to H_SYNC x cpp - 1.
- R7: data_valid is high on columns H_LEAD x cpp + correction through that value + H_ACTIVE x cpp - 1.
- R8: data_valid is high only on lines V_BLANK/2 to V_BLANK/2 + V_ACTIVE - 1, which is lines 2 to 241 by default.
- R9: A stop pulse forces idle outputs and zero counters on the next clock. It wins over a start pulse in the same cycle.
- R10: While running, changes on pix_mode and further start pulses have no effect on the raster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel-bus clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | launch the raster (accepted when idle) |
| stop | input | 1 | return to idle |
| pix_mode | input | 2 | bus clocks per pixel selector |
| hsync_n | output | 1 | horizontal sync, active low |
| vsync_n | output | 1 | vertical sync, active low |
| data_valid | output | 1 | active pixel clock strobe |
| col_o | output | COL_W | bus-clock column within the line |
| line_o | output | LINE_W | line within the frame |

## Verification
The bench builds the block with a shrunken raster: H_TOTAL 16, H_LEAD 3, H_ACTIVE 8, V_ACTIVE 4 and V_BLANK 4, with the default corrections of 3 and 5. At these sizes a whole frame lasts at most 384 clocks. Line wraps, frame wraps and the blank-line boundaries around the visible region therefore recur many times in every mode. Random start, stop and mode traffic is then run across those wraps, mixed with directed cases: an illegal mode, a start and a stop together, and a mode change during a run.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic [1:0] {
    PM_ONE   = 2'b00,
    PM_TWO   = 2'b01,
    PM_THREE = 2'b10,
    PM_BAD   = 2'b11
  } pix_mode_e;

  function automatic int unsigned clocks_per_pixel(input logic [1:0] m);
    case (m)
      PM_ONE:   return 1;
      PM_TWO:   return 2;
      PM_THREE: return 3;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/lcdt_cfg.sv
module lcdt_cfg
  import lcdt_pkg::*;
#(
  parameter int H_TOTAL  = 336,
  parameter int H_SYNC   = 2,
  parameter int H_LEAD   = 7,
  parameter int H_ACTIVE = 320,
  parameter int DLY_M1   = 3,
  parameter int DLY_M2   = 5,
  parameter int COL_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [1:0]       mode,
  output logic             legal,
  output logic [COL_W-1:0] last_col,
  output logic [COL_W-1:0] sync_end,
  output logic [COL_W-1:0] first_px,
  output logic [COL_W-1:0] last_px
);

  logic [COL_W-1:0] d_last, d_sync, d_first, d_lastpx;
  logic [COL_W-1:0] s_last, s_sync, s_first, s_lastpx;

  always_comb begin
    int unsigned c;
    int unsigned dly;
    c   = clocks_per_pixel(mode);
    dly = 0;
    if (mode == PM_TWO)   dly = DLY_M1;
    if (mode == PM_THREE) dly = DLY_M2;
    legal = (c != 0);
    if (c == 0) begin
      d_last   = '0;
      d_sync   = '0;
      d_first  = '0;
      d_lastpx = '0;
    end else begin
      d_last   = COL_W'(H_TOTAL * c - 1);
      d_sync   = COL_W'(H_SYNC * c);
      d_first  = COL_W'(H_LEAD * c + dly);
      d_lastpx = COL_W'(H_LEAD * c + dly + H_ACTIVE * c - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_last   <= '0;
      s_sync   <= '0;
      s_first  <= '0;
      s_lastpx <= '0;
    end else if (load) begin
      s_last   <= d_last;
      s_sync   <= d_sync;
      s_first  <= d_first;
      s_lastpx <= d_lastpx;
    end
  end

  assign last_col = load ? d_last   : s_last;
  assign sync_end = load ? d_sync   : s_sync;
  assign first_px = load ? d_first  : s_first;
  assign last_px  = load ? d_lastpx : s_lastpx;

endmodule

// File: rtl/lcdt_counter.sv
module lcdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         adv,
  input  logic [W-1:0] last,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt,
  output logic         wrap
);

  assign wrap = adv && (q == last);

  always_comb begin
    if (clear)     nxt = '0;
    else if (wrap) nxt = '0;
    else if (adv)  nxt = q + W'(1);
    else           nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && q != last) |=> (q == $past(q) + W'(1)));

  assert_count_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && q == last) |=> (q == '0));

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
#(
  parameter int H_TOTAL  = 336,
  parameter int H_SYNC   = 2,
  parameter int H_LEAD   = 7,
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int V_BLANK  = 4,
  parameter int DLY_M1   = 3,
  parameter int DLY_M2   = 5,
  parameter int COL_W    = $clog2(H_TOTAL * 3),
  parameter int LINE_W   = $clog2(V_ACTIVE + V_BLANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic [1:0]        pix_mode,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              data_valid,
  output logic [COL_W-1:0]  col_o,
  output logic [LINE_W-1:0] line_o
);

  localparam int V_TOTAL = V_ACTIVE + V_BLANK;
  localparam int V_TOP   = V_BLANK / 2;
  localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(V_TOTAL - 1);
  localparam logic [LINE_W-1:0] VIS_FIRST  = LINE_W'(V_TOP);
  localparam logic [LINE_W-1:0] VIS_LAST   = LINE_W'(V_TOP + V_ACTIVE - 1);

  logic running, run_nx, launch, legal, clr;
  logic [COL_W-1:0] last_col, sync_end, first_px, last_px;
  logic [COL_W-1:0] h_q, h_nx;
  logic [LINE_W-1:0] v_q, v_nx;
  logic h_wrap, v_wrap;

  assign launch = !running && start && !stop && legal;
  assign run_nx = !stop && (running || launch);
  assign clr    = !run_nx || launch;

  lcdt_cfg #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_LEAD(H_LEAD), .H_ACTIVE(H_ACTIVE),
    .DLY_M1(DLY_M1), .DLY_M2(DLY_M2), .COL_W(COL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(launch), .mode(pix_mode),
    .legal(legal), .last_col(last_col), .sync_end(sync_end),
    .first_px(first_px), .last_px(last_px)
  );

  lcdt_counter #(.W(COL_W)) u_col (
    .clk(clk), .rst(rst), .clear(clr), .adv(running),
    .last(last_col), .q(h_q), .nxt(h_nx), .wrap(h_wrap)
  );

  lcdt_counter #(.W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .clear(clr), .adv(running && h_wrap),
    .last(LINE_LAST), .q(v_q), .nxt(v_nx), .wrap(v_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      hsync_n    <= 1'b1;
      vsync_n    <= 1'b1;
      data_valid <= 1'b0;
    end else begin
      running    <= run_nx;
      hsync_n    <= !(run_nx && (h_nx < sync_end));
      vsync_n    <= !(run_nx && (v_nx == '0) && (h_nx < sync_end));
      data_valid <= run_nx && (v_nx >= VIS_FIRST) && (v_nx <= VIS_LAST)
                    && (h_nx >= first_px) && (h_nx <= last_px);
    end
  end

  assign col_o  = h_q;
  assign line_o = v_q;

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    stop |=> (hsync_n && vsync_n && !data_valid && col_o == '0 && line_o == '0));

  assert_bad_mode_R2: assert property (@(posedge clk) disable iff (rst)
    (!running && start && pix_mode == PM_BAD) |=> (hsync_n && vsync_n && !data_valid));

  assert_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (!running && start && !stop && pix_mode != PM_BAD)
      |=> (!hsync_n && !vsync_n && col_o == '0 && line_o == '0));

  assert_vs_inside_hs_R6: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> !hsync_n);

  assert_valid_clear_of_sync_R7: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> hsync_n);

endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;

  localparam int HT = 16, HS = 2, HL = 3, HA = 8, VA = 4, VB = 4, D1 = 3, D2 = 5;
  localparam int VT = VA + VB;
  localparam int CW = $clog2(HT * 3);
  localparam int LW = $clog2(VT);

  logic clk = 0, rst = 1, start = 0, stop = 0;
  logic [1:0] pix_mode = 0;
  logic hsync_n, vsync_n, data_valid;
  logic [CW-1:0] col_o;
  logic [LW-1:0] line_o;

  int n_chk = 0, n_bad = 0;
  bit m_run = 0;
  int m_cpp = 0, m_dly = 0, m_col = 0, m_line = 0;
  string ctx = "R1";

  always #2 clk = ~clk;

  lcd_timing_gen #(
    .H_TOTAL(HT), .H_SYNC(HS), .H_LEAD(HL), .H_ACTIVE(HA),
    .V_ACTIVE(VA), .V_BLANK(VB), .DLY_M1(D1), .DLY_M2(D2),
    .COL_W(CW), .LINE_W(LW)
  ) i_lcd_timing_gen (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .pix_mode(pix_mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .data_valid(data_valid),
    .col_o(col_o), .line_o(line_o)
  );

  function automatic int cpp_for(input logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : (m == 2'b10) ? 3 : 0;
  endfunction

  function automatic int dly_for(input logic [1:0] m);
    return (m == 2'b01) ? D1 : (m == 2'b10) ? D2 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (ctx %s) %s: got %0d expected %0d at %0t", tag, ctx, what, act, exp, $time);
    end
  endtask

  // model of the coming clock edge, from the requirements
  task automatic model_edge();
    if (rst || stop) begin
      m_run = 0; m_col = 0; m_line = 0;
    end else if (!m_run) begin
      if (start && cpp_for(pix_mode) != 0) begin
        m_run = 1; m_cpp = cpp_for(pix_mode); m_dly = dly_for(pix_mode);
        m_col = 0; m_line = 0;
      end
    end else begin
      if (m_col == HT * m_cpp - 1) begin
        m_col = 0;
        m_line = (m_line == VT - 1) ? 0 : m_line + 1;
      end else m_col++;
    end
  endtask

  task automatic compare_all();
    bit hs, vs, dv;
    int f;
    hs = m_run && (m_col < HS * m_cpp);
    vs = hs && (m_line == 0);
    f  = HL * m_cpp + m_dly;
    dv = m_run && m_line >= VB / 2 && m_line < VB / 2 + VA
         && m_col >= f && m_col < f + HA * m_cpp;
    check("R5", "hsync_n", int'(hsync_n), int'(!hs));
    check("R6", "vsync_n", int'(vsync_n), int'(!vs));
    check("R7_R8", "data_valid", int'(data_valid), int'(dv));
    check("R4", "col_o", int'(col_o), m_col);
    check("R4", "line_o", int'(line_o), m_line);
  endtask

  task automatic step(input bit s, input bit p, input logic [1:0] m);
    start = s; stop = p; pix_mode = m;
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h1cd5;
    void'($urandom(seed));
    @(negedge clk);
    rst = 1;
    ctx = "R1";
    for (int i = 0; i < 3; i++) step(0, 0, 2'b00);
    rst = 0;
    step(0, 0, 2'b00);

    // R2: illegal mode start stays idle
    ctx = "R2";
    step(1, 0, 2'b11);
    for (int i = 0; i < 20; i++) step(0, 0, 2'b11);

    // full frames in every legal mode (R3, R4..R8), then stop (R9)
    for (int md = 0; md < 3; md++) begin
      ctx = "R3";
      step(1, 0, 2'(md));
      ctx = "R8";
      for (int i = 0; i < 2 * VT * HT * (md + 1) + 5; i++) step(0, 0, 2'(md));
      ctx = "R9";
      step(0, 1, 2'(md));
      step(0, 0, 2'(md));
    end

    // R9: stop wins over start in the same cycle
    ctx = "R9";
    step(1, 1, 2'b00);
    step(0, 0, 2'b00);

    // R10: mode changes and restarts while running are ignored
    ctx = "R10";
    step(1, 0, 2'b01);
    for (int i = 0; i < 300; i++) step(i % 7 == 0, 0, 2'(i % 4));
    step(0, 1, 2'b00);

    // constrained random traffic
    ctx = "rand";
    for (int i = 0; i < 20000; i++) begin
      bit s, p;
      s = ($urandom % 40) == 0;
      p = ($urandom % 500) == 0;
      step(s, p, 2'($urandom % 4));
    end

    summary();
    $finish;
  end

endmodule